// File: doc/BRIEF.md
# Camera Receiver Control and Interrupt Register Block

This block is the software-visible control plane of a multi-lane camera receiver. It sits on an AXI4-Lite slave port and holds the run/soft-reset controls and the lane selection. It also keeps a saturating count of long packets and shows four live datapath status flags. Interrupts are handled by a global enable, a per-source enable and a write-one-to-clear pending register, which together drive one interrupt line.

The datapath reports events as single-cycle pulses on `evt_i` and long packets as pulses on `pkt_done_i`. The block watches its own lane setting and raises a pending bit when the selected lane count is larger than the count the receiver was built with. Everything runs on one clock. Accesses always complete with an OKAY response, whatever the address.

Top module: `cam_rx_regs`

## Requirements
- R1: Only address bits 6:2 select a register; bits above 6 and bits 1:0 are ignored, so 0x80 reads the word at 0x00 and 0xA8 writes the word at 0x28.
- R2: Write strobes have no effect (every write updates the full word); a write to an unmapped word changes nothing and a read of one returns 0; every response is OKAY (2'b00).
- R3: Bits with no defined function read as zero. Implemented pending/enable bits are 31, 21:17 and 13:0 (mask 0x803E3FFF); `evt_i` bit 16 and bits 30:22 are never stored.
- R4: After reset the word at 0x00 reads 0x1 (bit 0 run enable = 1, bit 1 soft reset = 0); `core_en_o` and `soft_rst_o` follow those bits.
- R5: While soft reset is 1, the global enable, per-source enable, pending bits and packet count are held at 0 and writes to them are lost; run enable, soft reset and the active-lane field keep their values and stay writable.
- R6: The word at 0x04 holds active lanes in bits 1:0 (read/write, reset = MAX_LANES-1, driven on `active_lanes_o`) and maximum lanes in bits 4:3 (read-only, MAX_LANES-1); code n means n+1 lanes.
- R7: Pending bit 21 is set on every cycle in which active lanes exceed maximum lanes, so clearing it has no lasting effect while the condition stands; `evt_i` bit 21 is ignored.
- R8: The word at 0x10 holds a 16-bit count in bits 31:16 that rises by one per `pkt_done_i` cycle and stays at 0xFFFF instead of wrapping.
- R9: Each `evt_i` pulse on an implemented bit sets the matching pending bit at 0x24; writing 1 to a pending bit clears it, writing 0 leaves it.
- R10: When an event and a clearing write hit the same pending bit in one cycle, the bit ends up set.
- R11: `irq_o` is 1 exactly when the global enable (0x20 bit 0, reset 0) is 1 and some pending bit is 1 with its enable bit at 0x28 also 1.
- R12: A write response stays valid until `bready_i`, a read response stays valid with stable data until `rready_i`, and no new access is taken while a response is waiting.
- R13: Bits 3:0 of the word at 0x10 show `stat_i` as it was in the read-accept cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awaddr_i | input | ADDR_W | Write address |
| awvalid_i | input | 1 | Write address valid |
| awready_o | output | 1 | Write address ready |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Write strobes (ignored) |
| wvalid_i | input | 1 | Write data valid |
| wready_o | output | 1 | Write data ready |
| bresp_o | output | 2 | Write response, always OKAY |
| bvalid_o | output | 1 | Write response valid |
| bready_i | input | 1 | Write response ready |
| araddr_i | input | ADDR_W | Read address |
| arvalid_i | input | 1 | Read address valid |
| arready_o | output | 1 | Read address ready |
| rdata_o | output | 32 | Read data |
| rresp_o | output | 2 | Read response, always OKAY |
| rvalid_o | output | 1 | Read data valid |
| rready_i | input | 1 | Read data ready |
| evt_i | input | 32 | Event pulses, one per pending bit |
| pkt_done_i | input | 1 | Long packet written pulse |
| stat_i | input | STAT_W | Live datapath status flags |
| core_en_o | output | 1 | Run enable |
| soft_rst_o | output | 1 | Soft reset |
| active_lanes_o | output | 2 | Active lane code |
| irq_o | output | 1 | Interrupt request |

## Verification
Two collisions matter most. One is a datapath event landing in the same cycle as a software write-one-to-clear on the same pending bit. The bench provokes it by raising `evt_i` in the very cycle the write handshake completes, and then reads the bit back expecting it set. The other is soft reset meeting events, packet pulses and register writes. Here events and writes are issued while soft reset is held, and the bench confirms that the cleared registers stay at zero while the lane field and controls keep their values. A behavioural model in the bench tracks every register and is compared against the outputs on every clock.

// File: rtl/cam_rx_regs_pkg.sv
package cam_rx_regs_pkg;
  localparam int DEC_W = 7;
  localparam int DATA_W = 32;
  localparam int LANE_W = 2;
  localparam logic [DEC_W-1:0] OFF_CFG   = 7'h00;
  localparam logic [DEC_W-1:0] OFF_PROTO = 7'h04;
  localparam logic [DEC_W-1:0] OFF_STAT  = 7'h10;
  localparam logic [DEC_W-1:0] OFF_GIE   = 7'h20;
  localparam logic [DEC_W-1:0] OFF_ISR   = 7'h24;
  localparam logic [DEC_W-1:0] OFF_IER   = 7'h28;
  localparam int LANE_ERR_BIT = 21;
  localparam logic [DATA_W-1:0] ISR_MASK = 32'h803E_3FFF;
  localparam logic [DATA_W-1:0] EVT_MASK = 32'h801E_3FFF;

  typedef struct packed {
    logic              en;
    logic [DEC_W-1:0]  addr;
    logic [DATA_W-1:0] data;
  } wr_cmd_t;
endpackage

// File: rtl/cam_rx_axil_if.sv
module cam_rx_axil_if
  import cam_rx_regs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [3:0]        wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output wr_cmd_t           wr_cmd_o,
  output logic [DEC_W-1:0]  rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i
);
  logic wr_fire, rd_fire;
  logic bvalid_q, rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic unused_bits;

  assign unused_bits = ^{wstrb_i, awaddr_i[ADDR_W-1:DEC_W], awaddr_i[1:0],
                         araddr_i[ADDR_W-1:DEC_W], araddr_i[1:0]};

  assign wr_fire   = awvalid_i && wvalid_i && !bvalid_q;
  assign awready_o = wr_fire;
  assign wready_o  = wr_fire;
  assign rd_fire   = arvalid_i && !rvalid_q;
  assign arready_o = !rvalid_q;

  assign wr_cmd_o.en   = wr_fire;
  assign wr_cmd_o.addr = {awaddr_i[DEC_W-1:2], 2'b00};
  assign wr_cmd_o.data = wdata_i;
  assign rd_addr_o     = {araddr_i[DEC_W-1:2], 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      if (wr_fire)       bvalid_q <= 1'b1;
      else if (bready_i) bvalid_q <= 1'b0;
      if (rd_fire) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_data_i;
      end else if (rready_i) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  assign bvalid_o = bvalid_q;
  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/cam_rx_ctrl_regs.sv
module cam_rx_ctrl_regs
  import cam_rx_regs_pkg::*;
#(
  parameter int MAX_LANES = 2,
  parameter int CNT_W     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_cmd_t           wr_cmd_i,
  input  logic              pkt_done_i,
  output logic              en_o,
  output logic              soft_o,
  output logic [LANE_W-1:0] act_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              lane_err_o
);
  localparam logic [LANE_W-1:0] MAX_CODE = LANE_W'(MAX_LANES - 1);

  logic              en_q, soft_q;
  logic [LANE_W-1:0] act_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b1;
      soft_q <= 1'b0;
      act_q  <= MAX_CODE;
    end else if (wr_cmd_i.en) begin
      if (wr_cmd_i.addr == OFF_CFG) begin
        en_q   <= wr_cmd_i.data[0];
        soft_q <= wr_cmd_i.data[1];
      end
      if (wr_cmd_i.addr == OFF_PROTO) act_q <= wr_cmd_i.data[LANE_W-1:0];
    end
  end

  // Saturating packet counter, cleared by soft reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (soft_q)                    cnt_q <= '0;
    else if (pkt_done_i && cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign en_o       = en_q;
  assign soft_o     = soft_q;
  assign act_o      = act_q;
  assign cnt_o      = cnt_q;
  assign lane_err_o = act_q > MAX_CODE;
endmodule

// File: rtl/cam_rx_irq_ctrl.sv
module cam_rx_irq_ctrl
  import cam_rx_regs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wr_cmd_t           wr_cmd_i,
  input  logic              soft_i,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              lane_err_i,
  output logic              gie_o,
  output logic [DATA_W-1:0] ier_o,
  output logic [DATA_W-1:0] isr_o,
  output logic              irq_o
);
  logic              gie_q;
  logic [DATA_W-1:0] ier_q, isr_q, set_v, clr_v, isr_d;

  always_comb begin
    set_v = evt_i & EVT_MASK;
    set_v[LANE_ERR_BIT] = lane_err_i;
    clr_v = (wr_cmd_i.en && wr_cmd_i.addr == OFF_ISR) ? (wr_cmd_i.data & ISR_MASK) : '0;
    // set after clear: an event in the clearing cycle survives
    isr_d = (isr_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q <= 1'b0;
      ier_q <= '0;
      isr_q <= '0;
    end else if (soft_i) begin
      gie_q <= 1'b0;
      ier_q <= '0;
      isr_q <= '0;
    end else begin
      isr_q <= isr_d;
      if (wr_cmd_i.en && wr_cmd_i.addr == OFF_GIE) gie_q <= wr_cmd_i.data[0];
      if (wr_cmd_i.en && wr_cmd_i.addr == OFF_IER) ier_q <= wr_cmd_i.data & ISR_MASK;
    end
  end

  assign gie_o = gie_q;
  assign ier_o = ier_q;
  assign isr_o = isr_q;
  assign irq_o = gie_q && |(isr_q & ier_q);
endmodule

// File: rtl/cam_rx_regs.sv
module cam_rx_regs
  import cam_rx_regs_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_LANES = 2,
  parameter int CNT_W     = 16,
  parameter int STAT_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [31:0]       rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  input  logic [31:0]       evt_i,
  input  logic              pkt_done_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              core_en_o,
  output logic              soft_rst_o,
  output logic [1:0]        active_lanes_o,
  output logic              irq_o
);
  localparam logic [LANE_W-1:0] MAX_CODE = LANE_W'(MAX_LANES - 1);

  wr_cmd_t           wr_cmd;
  logic [DEC_W-1:0]  rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] isr_q, ier_q;
  logic              gie_q, lane_err;

  cam_rx_axil_if #(.ADDR_W(ADDR_W)) u_bus (
    .clk_i, .rst_ni,
    .awaddr_i, .awvalid_i, .awready_o,
    .wdata_i, .wstrb_i, .wvalid_i, .wready_o,
    .bvalid_o, .bready_i,
    .araddr_i, .arvalid_i, .arready_o,
    .rdata_o, .rvalid_o, .rready_i,
    .wr_cmd_o (wr_cmd),
    .rd_addr_o(rd_addr),
    .rd_data_i(rd_data)
  );

  cam_rx_ctrl_regs #(.MAX_LANES(MAX_LANES), .CNT_W(CNT_W)) u_ctrl (
    .clk_i, .rst_ni,
    .wr_cmd_i  (wr_cmd),
    .pkt_done_i,
    .en_o      (core_en_o),
    .soft_o    (soft_rst_o),
    .act_o     (active_lanes_o),
    .cnt_o     (cnt_q),
    .lane_err_o(lane_err)
  );

  cam_rx_irq_ctrl u_irq (
    .clk_i, .rst_ni,
    .wr_cmd_i  (wr_cmd),
    .soft_i    (soft_rst_o),
    .evt_i,
    .lane_err_i(lane_err),
    .gie_o     (gie_q),
    .ier_o     (ier_q),
    .isr_o     (isr_q),
    .irq_o
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFF_CFG:   rd_data[1:0] = {soft_rst_o, core_en_o};
      OFF_PROTO: begin
        rd_data[4:3] = MAX_CODE;
        rd_data[1:0] = active_lanes_o;
      end
      OFF_STAT: begin
        rd_data[DATA_W-1 -: CNT_W] = cnt_q;
        rd_data[STAT_W-1:0]        = stat_i;
      end
      OFF_GIE:   rd_data[0] = gie_q;
      OFF_ISR:   rd_data = isr_q;
      OFF_IER:   rd_data = ier_q;
      default:   rd_data = '0;
    endcase
  end

  assign bresp_o = 2'b00;
  assign rresp_o = 2'b00;
endmodule

// File: rtl/cam_rx_regs_chk.sv
module cam_rx_regs_chk
  import cam_rx_regs_pkg::*;
#(
  parameter int MAX_LANES = 2,
  parameter int CNT_W     = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_o,
  input logic              pkt_done_i,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [DATA_W-1:0] evt_i,
  input logic [DATA_W-1:0] isr_q,
  input logic [DATA_W-1:0] ier_q,
  input logic              gie_q,
  input logic [1:0]        active_lanes_o,
  input logic              bvalid_o,
  input logic              bready_i,
  input logic              rvalid_o,
  input logic              rready_i,
  input logic [DATA_W-1:0] rdata_o
);
  localparam logic [1:0] MAX_CODE = 2'(MAX_LANES - 1);

  p_cnt_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_o && pkt_done_i && cnt_q != '1) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  p_no_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_o && cnt_q == '1) |=> cnt_q == '1);

  p_soft_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (isr_q == '0 && ier_q == '0 && !gie_q && cnt_q == '0));

  p_evt_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_o && |(evt_i & EVT_MASK))
      |=> ((isr_q & $past(evt_i & EVT_MASK)) == $past(evt_i & EVT_MASK)));

  p_lane_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!soft_rst_o && active_lanes_o > MAX_CODE) |=> isr_q[LANE_ERR_BIT]);

  p_bhold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bvalid_o && !bready_i) |=> bvalid_o);

  p_rhold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !rready_i) |=> (rvalid_o && $stable(rdata_o)));
endmodule

bind cam_rx_regs cam_rx_regs_chk #(.MAX_LANES(MAX_LANES), .CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .soft_rst_o    (soft_rst_o),
  .pkt_done_i    (pkt_done_i),
  .cnt_q         (cnt_q),
  .evt_i         (evt_i),
  .isr_q         (isr_q),
  .ier_q         (ier_q),
  .gie_q         (gie_q),
  .active_lanes_o(active_lanes_o),
  .bvalid_o      (bvalid_o),
  .bready_i      (bready_i),
  .rvalid_o      (rvalid_o),
  .rready_i      (rready_i),
  .rdata_o       (rdata_o)
);

// File: tb/cam_rx_regs_test.sv
module cam_rx_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] IMPL = 32'h803E_3FFF;
  localparam logic [31:0] EVTM = 32'h801E_3FFF;
  localparam logic [1:0]  MAXC = 2'd1;

  logic clk = 0, rst_n = 0;
  logic [31:0] awaddr = 0, wdata = 0, araddr = 0, evt = 0;
  logic [3:0]  wstrb = 4'hF, stat = 0;
  logic awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1, pkt = 0;
  logic awready, wready, bvalid, arready, rvalid, core_en, soft_rst, irq;
  logic [1:0] bresp, rresp, lanes;
  logic [31:0] rdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cam_rx_regs uut (
    .clk_i(clk), .rst_ni(rst_n),
    .awaddr_i(awaddr), .awvalid_i(awvalid), .awready_o(awready),
    .wdata_i(wdata), .wstrb_i(wstrb), .wvalid_i(wvalid), .wready_o(wready),
    .bresp_o(bresp), .bvalid_o(bvalid), .bready_i(bready),
    .araddr_i(araddr), .arvalid_i(arvalid), .arready_o(arready),
    .rdata_o(rdata), .rresp_o(rresp), .rvalid_o(rvalid), .rready_i(rready),
    .evt_i(evt), .pkt_done_i(pkt), .stat_i(stat),
    .core_en_o(core_en), .soft_rst_o(soft_rst), .active_lanes_o(lanes), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  logic m_en, m_soft, m_gie, m_bv, m_rv;
  logic [1:0] m_act;
  logic [15:0] m_cnt;
  logic [31:0] m_ier, m_isr, m_rd;

  function automatic logic [31:0] model_read(input logic [31:0] a);
    case (a[6:0] & 7'h7C)
      7'h00: return {30'd0, m_soft, m_en};
      7'h04: return {27'd0, MAXC, 1'b0, m_act};
      7'h10: return {m_cnt, 12'd0, stat};
      7'h20: return {31'd0, m_gie};
      7'h24: return m_isr;
      7'h28: return m_ier;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    logic wf, rf;
    logic [31:0] w1c, n_isr, n_ier;
    logic n_en, n_soft, n_gie;
    logic [1:0] n_act;
    logic [15:0] n_cnt;
    if (!rst_n) begin
      m_en = 1; m_soft = 0; m_act = MAXC; m_cnt = 0; m_gie = 0;
      m_ier = 0; m_isr = 0; m_bv = 0; m_rv = 0; m_rd = 0;
    end else begin
      wf = awvalid && wvalid && !m_bv;
      rf = arvalid && !m_rv;
      if (rf) m_rd = model_read(araddr);
      n_en = m_en; n_soft = m_soft; n_act = m_act; n_gie = m_gie; n_ier = m_ier;
      w1c = 0;
      if (wf) begin
        case (awaddr[6:0] & 7'h7C)
          7'h00: begin n_en = wdata[0]; n_soft = wdata[1]; end
          7'h04: n_act = wdata[1:0];
          7'h20: n_gie = wdata[0];
          7'h24: w1c = wdata & IMPL;
          7'h28: n_ier = wdata & IMPL;
          default: ;
        endcase
      end
      n_isr = (m_isr & ~w1c) | (evt & EVTM) | ((m_act > MAXC) ? 32'h0020_0000 : 32'h0);
      n_cnt = (pkt && m_cnt != 16'hFFFF) ? m_cnt + 16'd1 : m_cnt;
      if (m_soft) begin n_gie = 0; n_ier = 0; n_isr = 0; n_cnt = 0; end
      m_bv = wf ? 1'b1 : (bready ? 1'b0 : m_bv);
      m_rv = rf ? 1'b1 : (rready ? 1'b0 : m_rv);
      m_en = n_en; m_soft = n_soft; m_act = n_act; m_gie = n_gie;
      m_ier = n_ier; m_isr = n_isr; m_cnt = n_cnt;
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 core_en", {31'd0, core_en}, {31'd0, m_en});
      chk("R5 soft_rst", {31'd0, soft_rst}, {31'd0, m_soft});
      chk("R6 lanes", {30'd0, lanes}, {30'd0, m_act});
      chk("R11 irq", {31'd0, irq}, {31'd0, m_gie && |(m_isr & m_ier)});
      chk("R12 bvalid", {31'd0, bvalid}, {31'd0, m_bv});
      chk("R12 rvalid", {31'd0, rvalid}, {31'd0, m_rv});
      if (m_rv) chk("R1 rdata model", rdata, m_rd);
    end
  end

  task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    araddr = a; arvalid = 1;
    @(negedge clk);
    arvalid = 0;
    chk(req, rdata, exp);
    chk({req, " rresp"}, {30'd0, rresp}, 32'd0);
  endtask

  task automatic pulse_evt(input logic [31:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R4 / R6 reset state
    chk("R4 reset core_en", {31'd0, core_en}, 32'd1);
    chk("R4 reset soft", {31'd0, soft_rst}, 32'd0);
    chk("R6 reset lanes", {30'd0, lanes}, 32'd1);
    rd(32'h00, 32'h1, "R4 cfg reset");
    rd(32'h04, 32'h09, "R6 proto reset");
    rd(32'h10, 32'h0, "R8 status reset");
    rd(32'h24, 32'h0, "R9 isr reset");
    rd(32'h20, 32'h0, "R11 gie reset");

    // R1 alias, R2 strobes ignored, R3 reserved zero
    wr(32'hA8, 32'hFFFF_FFFF, 4'h0);
    rd(32'h28, 32'h803E_3FFF, "R2 R3 ier via alias");
    rd(32'h80, 32'h1, "R1 alias of cfg");
    wr(32'h0C, 32'hFFFF_FFFF);
    rd(32'h0C, 32'h0, "R2 unmapped");

    // R9 / R3 / R7 events, R11 gating
    pulse_evt(32'h8021_0001);
    rd(32'h24, 32'h8000_0001, "R9 R3 R7 isr after events");
    chk("R11 gie off", {31'd0, irq}, 32'd0);
    wr(32'h20, 32'h1);
    chk("R11 gie on", {31'd0, irq}, 32'd1);
    wr(32'h28, 32'h0);
    chk("R11 ier zero", {31'd0, irq}, 32'd0);
    wr(32'h28, 32'h8000_0000);
    chk("R11 ier bit31", {31'd0, irq}, 32'd1);
    wr(32'h24, 32'h8000_0000);
    chk("R11 after clear", {31'd0, irq}, 32'd0);
    rd(32'h24, 32'h1, "R9 w1c partial");

    // R10 same-cycle event and clear
    wr(32'h24, 32'hFFFF_FFFF);
    @(negedge clk);
    awaddr = 32'h24; wdata = 32'h1; awvalid = 1; wvalid = 1; evt = 32'h1;
    @(negedge clk);
    awvalid = 0; wvalid = 0; evt = 0;
    rd(32'h24, 32'h1, "R10 event wins");
    wr(32'h24, 32'h1);
    rd(32'h24, 32'h0, "R9 cleared");

    // R7 lane error, R6 read-only max
    wr(32'h04, 32'h2);
    chk("R6 lanes out", {30'd0, lanes}, 32'd2);
    rd(32'h24, 32'h0020_0000, "R7 lane error set");
    wr(32'h24, 32'h0020_0000);
    rd(32'h24, 32'h0020_0000, "R7 persists");
    wr(32'h04, 32'hFFFF_FFFF);
    rd(32'h04, 32'h0B, "R6 max read-only");
    wr(32'h04, 32'h1);
    wr(32'h24, 32'h0020_0000);
    rd(32'h24, 32'h0, "R7 cleared after fix");

    // R13 live status, R8 count and saturation
    stat = 4'hA;
    rd(32'h10, 32'h0000_000A, "R13 live status");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); pkt = 1;
      @(negedge clk); pkt = 0;
    end
    rd(32'h10, 32'h0005_000A, "R8 count five");
    @(negedge clk); pkt = 1;
    repeat (70000) @(negedge clk);
    pkt = 0;
    rd(32'h10, 32'hFFFF_000A, "R8 saturated");

    // R12 response held
    bready = 0;
    wr(32'h30, 32'h0);
    repeat (3) @(negedge clk);
    chk("R12 bvalid held", {31'd0, bvalid}, 32'd1);
    chk("R12 no new accept", {31'd0, awready}, 32'd0);
    bready = 1;
    @(negedge clk);
    chk("R12 bvalid released", {31'd0, bvalid}, 32'd0);
    rready = 0;
    @(negedge clk); araddr = 32'h04; arvalid = 1;
    @(negedge clk); arvalid = 0;
    repeat (2) @(negedge clk);
    chk("R12 rdata held", rdata, 32'h09);
    rready = 1;
    @(negedge clk);

    // R5 soft reset
    wr(32'h20, 32'h1);
    wr(32'h28, 32'hFFFF_FFFF);
    pulse_evt(32'h20);
    wr(32'h04, 32'h0);
    chk("R11 before soft", {31'd0, irq}, 32'd1);
    wr(32'h00, 32'h3);
    rd(32'h24, 32'h0, "R5 isr cleared");
    rd(32'h20, 32'h0, "R5 gie cleared");
    rd(32'h28, 32'h0, "R5 ier cleared");
    rd(32'h10, 32'h0000_000A, "R5 count cleared");
    rd(32'h00, 32'h3, "R5 cfg kept");
    rd(32'h04, 32'h08, "R5 lanes kept");
    pulse_evt(32'h1);
    @(negedge clk); pkt = 1; @(negedge clk); pkt = 0;
    wr(32'h20, 32'h1);
    rd(32'h24, 32'h0, "R5 event lost");
    rd(32'h20, 32'h0, "R5 write lost");
    rd(32'h10, 32'h0000_000A, "R5 packet lost");
    wr(32'h00, 32'h1);
    pulse_evt(32'h1);
    rd(32'h24, 32'h1, "R5 events resume");
    wr(32'h00, 32'h0);
    chk("R4 core disabled", {31'd0, core_en}, 32'd0);
    wr(32'h00, 32'h1);
    @(negedge clk);
    finish_run();
  end
endmodule